// File: doc/BRIEF.md
# IOMMU configuration register file

This block is the software-visible configuration store of an I/O address translation unit. A simple single-beat bus issues one request per cycle: a word address, a read/write flag and, for writes, a 32-bit data word. Each register applies its own write rule. Most keep only the bits under a per-register mask. Some also force constant bits to one. One register accumulates by OR instead of replacing its contents.

The translator reads three values from the block. The first is the table base. The second is the enable bit. The third is a window start address, decoded from a three-bit size field at the moment the control register is written. The window always ends at the top of the 32-bit address space. Its size starts at 16 MB and doubles with each step of the field.

A read returns its data one cycle after the request, together with a one-cycle valid strobe. Fault status and fault address registers are kept in a separate block. Page-table walking is also outside this block.

Top module: `iomap_cfg_regs`

## Requirements
- R1: After reset the registers hold these values, all at word addresses: control (word 0x000) = VERSION bits 31:24 with all lower bits 0; arbiter-enable (word 0x402) = 0x00000003; arbitration-enable (word 0x800) = 0x00000008; mask-ID (word 0xC06) = 0x23000000. Every other register reads 0. `win_base` is 0, `xlat_en` is 0 and `rsp_valid` is 0.
- R2: A write to control stores (wdata AND 0x0000001D) OR (VERSION AND 0xFF000000).
- R3: A control write with size field r = wdata[4:2] sets `win_base` to 0xFFFFFFFF shifted left by 24+r (r=0 gives 0xFF000000, r=7 gives 0x80000000). The new value appears at the same edge the control register is written. `win_base` changes at no other time. `xlat_en` follows control bit 0.
- R4: A write to the table base register (word 0x001) keeps only bits under 0x07FFFC00. That register drives `table_base`.
- R5: The TLB flush register (word 0x005) and the page flush register (word 0x006) store the full written word.
- R6: A write to arbiter-enable keeps bits under 0x801F000F and forces bit 0 to 1.
- R7: There are four slot configuration registers, at words 0x404 to 0x407. Each write keeps bits under 0x00010003 and changes only the addressed slot.
- R8: A write to arbitration-enable keeps bits under 0x001F0000 and forces bit 3 (0x8) to 1.
- R9: A write to mask-ID ORs (wdata AND 0x00FFFFFF) into the current contents. Bits already set stay set.
- R10: A read of any word address not listed above returns 0. A write to such an address changes no register.
- R11: A read request makes `rsp_valid` high for exactly the next cycle, with `rsp_rdata` holding the register value as of the request cycle. A write raises no response. A read in the cycle right after a write sees the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address (byte offset divided by 4) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | 32 | Read data, 0 when no response |
| win_base | output | 32 | Start of the translated window |
| xlat_en | output | 1 | Translation enable (control bit 0) |
| table_base | output | 32 | Masked page-table base value |

## Verification
A control write updates two things at the same clock edge: the stored control word and the window start output. The bench issues a control write for each of the eight size codes. After each write it checks `win_base` and `xlat_en` at the next falling edge, then reads control back in the very next cycle. The window must already hold the value decoded from the new code, and the readback must show the masked word with the version bits. The same write-then-read sequence, issued back to back, is used on the mask-ID register. There it shows that the OR-accumulated contents are visible one cycle after the write.

// File: rtl/iomap_cfg_pkg.sv
package iomap_cfg_pkg;

    localparam int unsigned DW = 32;
    typedef logic [DW-1:0] word_t;

    // word indices (byte offset / 4)
    localparam int unsigned W_CTRL  = 'h000;
    localparam int unsigned W_BASE  = 'h001;
    localparam int unsigned W_TLBF  = 'h005;
    localparam int unsigned W_PGF   = 'h006;
    localparam int unsigned W_AER   = 'h402;
    localparam int unsigned W_SLOT0 = 'h404;
    localparam int unsigned W_ARB   = 'h800;
    localparam int unsigned W_MID   = 'hC06;

    // fixed-register select positions
    localparam int unsigned S_CTRL  = 0;
    localparam int unsigned S_BASE  = 1;
    localparam int unsigned S_TLBF  = 2;
    localparam int unsigned S_PGF   = 3;
    localparam int unsigned S_AER   = 4;
    localparam int unsigned S_ARB   = 5;
    localparam int unsigned S_MID   = 6;
    localparam int unsigned N_FIX   = 7;

    // write masks and forced bits
    localparam word_t M_CTRL = 32'h0000_001D;
    localparam word_t M_VER  = 32'hFF00_0000;
    localparam word_t M_BASE = 32'h07FF_FC00;
    localparam word_t M_AER  = 32'h801F_000F;
    localparam word_t F_AER  = 32'h0000_0001;
    localparam word_t M_SLOT = 32'h0001_0003;
    localparam word_t M_ARB  = 32'h001F_0000;
    localparam word_t F_ARB  = 32'h0000_0008;
    localparam word_t M_MID  = 32'h00FF_FFFF;

    // reset values
    localparam word_t R_AER  = 32'h0000_0003;
    localparam word_t R_ARB  = 32'h0000_0008;
    localparam word_t R_MID  = 32'h2300_0000;

    // window size field
    localparam int unsigned RNG_LSB      = 2;
    localparam int unsigned RNG_W        = 3;
    localparam int unsigned MIN_WIN_LOG2 = 24;

    function automatic int unsigned fix_word(input int unsigned k);
        case (k)
            S_CTRL:  return W_CTRL;
            S_BASE:  return W_BASE;
            S_TLBF:  return W_TLBF;
            S_PGF:   return W_PGF;
            S_AER:   return W_AER;
            S_ARB:   return W_ARB;
            default: return W_MID;
        endcase
    endfunction

    typedef struct packed {
        word_t ctrl;
        word_t base;
        word_t tlbf;
        word_t pgf;
        word_t aer;
        word_t arb;
        word_t mid;
        word_t win;
        logic  rsp_v;
        word_t rsp_d;
    } cfg_state_t;

endpackage

// File: rtl/iomap_addr_dec.sv
module iomap_addr_dec
    import iomap_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_SLOTS = 4
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [N_FIX-1:0]     sel_fix,
    output logic [NUM_SLOTS-1:0] sel_slot,
    output logic                 hit
);

    for (genvar k = 0; k < N_FIX; k++) begin : g_fix
        localparam int unsigned WIDX = fix_word(k);
        assign sel_fix[k] = (addr == ADDR_W'(WIDX));
    end

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam int unsigned WIDX = W_SLOT0 + i;
        assign sel_slot[i] = (addr == ADDR_W'(WIDX));
    end

    assign hit = (|sel_fix) | (|sel_slot);

endmodule

// File: rtl/iomap_win_dec.sv
module iomap_win_dec
    import iomap_cfg_pkg::*;
#(
    parameter int unsigned MIN_LOG2 = MIN_WIN_LOG2
) (
    input  logic [RNG_W-1:0] rng,
    output word_t            base
);

    localparam word_t ALL_ONES = {DW{1'b1}};

    always_comb begin
        base = ALL_ONES << (MIN_LOG2 + 32'(rng));
    end

endmodule

// File: rtl/iomap_slot_bank.sv
module iomap_slot_bank
    import iomap_cfg_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [NUM_SLOTS-1:0]         sel_slot,
    input  word_t                        wdata,
    output logic [NUM_SLOTS-1:0][DW-1:0] slot_val
);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        word_t slot_d;
        word_t slot_q;

        always_comb begin
            slot_d = slot_q;
            if (wr_en && sel_slot[i]) begin
                slot_d = wdata & M_SLOT;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign slot_val[i] = slot_q;
    end

endmodule

// File: rtl/iomap_cfg_regs.sv
module iomap_cfg_regs
    import iomap_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_SLOTS = 4,
    parameter logic [31:0] VERSION   = 32'h0400_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic [31:0]       win_base,
    output logic              xlat_en,
    output logic [31:0]       table_base
);

    localparam word_t VER_BITS = VERSION & M_VER;

    localparam cfg_state_t RST_STATE = '{
        ctrl:  VER_BITS,
        base:  '0,
        tlbf:  '0,
        pgf:   '0,
        aer:   R_AER,
        arb:   R_ARB,
        mid:   R_MID,
        win:   '0,
        rsp_v: 1'b0,
        rsp_d: '0
    };

    cfg_state_t st_d;
    cfg_state_t st_q;

    logic [N_FIX-1:0]             sel_fix;
    logic [NUM_SLOTS-1:0]         sel_slot;
    logic                         hit;
    logic                         wr_en;
    logic                         rd_en;
    word_t                        win_new;
    word_t                        rd_mux;
    logic [NUM_SLOTS-1:0][DW-1:0] slot_val;

    assign wr_en = req_valid &&  req_write;
    assign rd_en = req_valid && !req_write;

    iomap_addr_dec #(
        .ADDR_W    (ADDR_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) addr_dec_i (
        .addr     (req_addr),
        .sel_fix  (sel_fix),
        .sel_slot (sel_slot),
        .hit      (hit)
    );

    iomap_win_dec #(
        .MIN_LOG2 (MIN_WIN_LOG2)
    ) win_dec_i (
        .rng  (req_wdata[RNG_LSB +: RNG_W]),
        .base (win_new)
    );

    iomap_slot_bank #(
        .NUM_SLOTS (NUM_SLOTS)
    ) slot_bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .sel_slot (sel_slot),
        .wdata    (req_wdata),
        .slot_val (slot_val)
    );

    // read data select; unmapped words fall through to zero
    always_comb begin
        rd_mux = '0;
        if (hit) begin
            if (sel_fix[S_CTRL]) rd_mux = st_q.ctrl;
            if (sel_fix[S_BASE]) rd_mux = st_q.base;
            if (sel_fix[S_TLBF]) rd_mux = st_q.tlbf;
            if (sel_fix[S_PGF])  rd_mux = st_q.pgf;
            if (sel_fix[S_AER])  rd_mux = st_q.aer;
            if (sel_fix[S_ARB])  rd_mux = st_q.arb;
            if (sel_fix[S_MID])  rd_mux = st_q.mid;
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (sel_slot[i]) rd_mux = slot_val[i];
            end
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.rsp_v = rd_en;
        st_d.rsp_d = rd_en ? rd_mux : '0;
        if (wr_en) begin
            if (sel_fix[S_CTRL]) begin
                st_d.ctrl = (req_wdata & M_CTRL) | VER_BITS;
                st_d.win  = win_new;
            end
            if (sel_fix[S_BASE]) st_d.base = req_wdata & M_BASE;
            if (sel_fix[S_TLBF]) st_d.tlbf = req_wdata;
            if (sel_fix[S_PGF])  st_d.pgf  = req_wdata;
            if (sel_fix[S_AER])  st_d.aer  = (req_wdata & M_AER) | F_AER;
            if (sel_fix[S_ARB])  st_d.arb  = (req_wdata & M_ARB) | F_ARB;
            if (sel_fix[S_MID])  st_d.mid  = st_q.mid | (req_wdata & M_MID);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid  = st_q.rsp_v;
    assign rsp_rdata  = st_q.rsp_d;
    assign win_base   = st_q.win;
    assign xlat_en    = st_q.ctrl[0];
    assign table_base = st_q.base;

endmodule

// File: rtl/iomap_cfg_chk.sv
module iomap_cfg_chk
    import iomap_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_SLOTS = 4,
    parameter logic [31:0] VERSION   = 32'h0400_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic [31:0]       win_base,
    input logic              xlat_en,
    input logic [31:0]       table_base
);

    logic is_rd;
    logic ctrl_wr;
    assign is_rd   = req_valid && !req_write;
    assign ctrl_wr = req_valid && req_write && (req_addr == ADDR_W'(W_CTRL));

    // R11: every read is answered in the next cycle
    a_r11_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> rsp_valid);

    // R11: no response without a read
    a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> !rsp_valid);

    // R3: window only moves on a control write
    a_r3_win_held: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(win_base));

    // R3: window is zero or a run of ones reaching the top bit
    a_r3_win_shape: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(32'(~win_base + 32'd1)) && (win_base[MIN_WIN_LOG2-1:0] == '0));

    // R3: enable rises only through a control write setting bit 0
    a_r3_en_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xlat_en) |-> $past(ctrl_wr && req_wdata[0]));

    // R2: control readback carries the version byte
    a_r2_version_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(is_rd && req_addr == ADDR_W'(W_CTRL)))
            |-> (rsp_rdata[31:24] == VERSION[31:24]));

    // R6: arbiter-enable bit 0 always reads as one
    a_r6_aer_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(is_rd && req_addr == ADDR_W'(W_AER)))
            |-> rsp_rdata[0]);

    // R8: arbitration-enable bit 3 always reads as one
    a_r8_arb_bit3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(is_rd && req_addr == ADDR_W'(W_ARB)))
            |-> rsp_rdata[3]);

endmodule

bind iomap_cfg_regs iomap_cfg_chk #(
    .ADDR_W    (ADDR_W),
    .NUM_SLOTS (NUM_SLOTS),
    .VERSION   (VERSION)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .win_base   (win_base),
    .xlat_en    (xlat_en),
    .table_base (table_base)
);

// File: tb/iomap_cfg_regs_tb_top.sv
module iomap_cfg_regs_tb_top;

    localparam logic [31:0] VER     = 32'h4A00_00FF;
    localparam logic [31:0] VER_EXP = 32'h4A00_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [31:0] win_base;
    logic        xlat_en;
    logic [31:0] table_base;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    iomap_cfg_regs #(
        .ADDR_W    (12),
        .NUM_SLOTS (4),
        .VERSION   (VER)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .win_base   (win_base),
        .xlat_en    (xlat_en),
        .table_base (table_base)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = a;
        req_wdata = 32'h5555_AAAA;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: compare each response against the scoreboard head (R11)
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                n_vec++;
                n_fail++;
                $display("FAIL R11 unexpected response actual=%h expected=none", rsp_rdata);
            end else begin
                chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL R11 watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs while in reset
        chk("R1 rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
        chk("R1 win_base in reset", win_base, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 xlat_en after reset", {31'b0, xlat_en}, 32'h0);
        chk("R1 table_base after reset", table_base, 32'h0);

        // R1: reset contents
        rd(12'h000, VER_EXP,      "R1 ctrl reset");
        rd(12'h001, 32'h0,        "R1 base reset");
        rd(12'h005, 32'h0,        "R1 tlb flush reset");
        rd(12'h006, 32'h0,        "R1 page flush reset");
        rd(12'h402, 32'h3,        "R1 arbiter-enable reset");
        rd(12'h800, 32'h8,        "R1 arbitration-enable reset");
        rd(12'hC06, 32'h2300_0000,"R1 mask-ID reset");
        for (int i = 0; i < 4; i++) rd(12'(12'h404 + i), 32'h0, "R1 slot reset");

        // R2/R3: all ones into control
        wr(12'h000, 32'hFFFF_FFFF);
        chk("R3 window r=7", win_base, 32'h8000_0000);
        chk("R3 enable set", {31'b0, xlat_en}, 32'h1);
        rd(12'h000, VER_EXP | 32'h1D, "R2 ctrl all ones");

        // R3: every size code, read back right after write
        for (int r = 0; r < 8; r++) begin
            wr(12'h000, 32'(r << 2));
            chk("R3 window sweep", win_base, 32'hFFFF_FFFF << (24 + r));
            chk("R3 enable clear", {31'b0, xlat_en}, 32'h0);
            rd(12'h000, VER_EXP | 32'(r << 2), "R2 ctrl sweep");
        end
        wr(12'h000, 32'hFFFF_FFE1);
        chk("R3 window r=0 with enable", win_base, 32'hFF00_0000);
        chk("R3 enable bit0", {31'b0, xlat_en}, 32'h1);
        rd(12'h000, VER_EXP | 32'h1, "R2 ctrl stray bits dropped");

        // R4
        wr(12'h001, 32'hFFFF_FFFF);
        chk("R4 table_base all ones", table_base, 32'h07FF_FC00);
        wr(12'h001, 32'h1234_5678);
        rd(12'h001, 32'h1234_5678 & 32'h07FF_FC00, "R4 base masked");
        chk("R3 window unchanged by base write", win_base, 32'hFF00_0000);

        // R5
        wr(12'h005, 32'hDEAD_BEEF);
        wr(12'h006, 32'hCAFE_F00D);
        rd(12'h005, 32'hDEAD_BEEF, "R5 tlb flush");
        rd(12'h006, 32'hCAFE_F00D, "R5 page flush");

        // R6
        wr(12'h402, 32'h0);
        rd(12'h402, 32'h1, "R6 aer forced bit0");
        wr(12'h402, 32'hFFFF_FFFF);
        rd(12'h402, 32'h801F_000F, "R6 aer mask");

        // R7: single slot, then all with distinct values
        wr(12'h406, 32'hFFFF_FFFF);
        for (int i = 0; i < 4; i++)
            rd(12'(12'h404 + i), (i == 2) ? 32'h0001_0003 : 32'h0, "R7 slot isolation");
        for (int i = 0; i < 4; i++) wr(12'(12'h404 + i), 32'(i) * 32'h0001_4001);
        for (int i = 0; i < 4; i++)
            rd(12'(12'h404 + i), (32'(i) * 32'h0001_4001) & 32'h0001_0003, "R7 slot pattern");

        // R8
        wr(12'h800, 32'h0);
        rd(12'h800, 32'h8, "R8 arb forced bit3");
        wr(12'h800, 32'hFFFF_FFFF);
        rd(12'h800, 32'h001F_0008, "R8 arb mask");

        // R9: OR accumulate, read back-to-back
        wr(12'hC06, 32'h0000_00F0);
        rd(12'hC06, 32'h2300_00F0, "R9 mask-ID or 1");
        wr(12'hC06, 32'hFF00_000F);
        rd(12'hC06, 32'h2300_00FF, "R9 mask-ID upper byte ignored");
        wr(12'hC06, 32'h0012_3400);
        rd(12'hC06, 32'h2312_34FF, "R9 mask-ID accumulate");

        // R10
        rd(12'h003, 32'h0, "R10 unmapped 0x003");
        rd(12'h408, 32'h0, "R10 unmapped past slots");
        wr(12'h7FF, 32'hFFFF_FFFF);
        rd(12'h7FF, 32'h0, "R10 unmapped after write");
        wr(12'h002, 32'h0000_0010);
        chk("R10 window untouched", win_base, 32'hFF00_0000);
        rd(12'h000, VER_EXP | 32'h1, "R10 ctrl untouched");
        rd(12'h402, 32'h801F_000F, "R10 aer untouched");

        // R11: drain and confirm every read was answered
        repeat (3) @(negedge clk);
        chk("R11 scoreboard drained", 32'(exp_q.size()), 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule